// File: doc/BRIEF.md
# Video Scanline Type Sequencer

This block lays out the vertical structure of a video frame, one line at a time. A horizontal timing unit pulses `line_done` once at the end of each scanline. On that pulse the sequencer steps to the next line and reports four things for it: the line number, a 4-bit line type, the source image row for picture lines, and a flag that is high whenever the line carries no picture. A frame counter advances each time the line number returns to 1.

Two frame layouts are supported. A progressive frame is a single field: long vertical-sync lines, dark lines above the picture, picture lines, and dark lines below. An interlaced frame has two fields. Its sync intervals are made of lines that each hold two half-line pulses. The half-line pair can be vertical+vertical, horizontal+horizontal, vertical+horizontal or horizontal+vertical. In an interlaced frame, each field's picture lines map to either the even or the odd rows of the image. Line doubling can be enabled, so that every image row is shown on two successive lines.

The segment lengths and the mode flags come in on plain ports. The block copies them only at a frame boundary, so a frame that has started always runs to its end with one consistent configuration. The number of lines in a frame is the sum of the lines that the segments produce. Segments of length zero are skipped.

Top module: `vline_seq`

## Requirements
- R1: While `rst` is high, the outputs load the description of line 1 of frame 0 for the configuration on the ports: `line_num_o`=1, `frame_o`=0, and the type and row of the first non-empty segment.
- R2: Outputs change only on a clock edge where `line_done` is high (or during reset); at all other times they hold their value.
- R3: Each `line_done` increments `line_num_o`. After the last line of a frame, `line_num_o` returns to 1 and `frame_o` increments by one.
- R4: Progressive frame (`ilace_i`=0): `sync1_i` lines of long vsync, `back1_i` dark lines, `act1_i` picture lines, `front1_i` dark lines, in that order.
- R5: Interlaced field 1 (`ilace_i`=1), in this order:
  - `sync1_i`/2 vertical-pair lines;
  - one vertical+horizontal line if `sync1_i` is odd;
  - `post1_i`/2 horizontal-pair lines;
  - `back1_i` dark lines;
  - `act1_i` picture lines;
  - `front1_i` dark lines.
- R6: Interlaced field change and field 2, in this order, with k = `pre1_i` mod 2:
  - `pre1_i`/2 horizontal-pair lines;
  - one horizontal+vertical line if k=1;
  - (`sync2_i`−k)/2 vertical-pair lines;
  - one vertical+horizontal line if (`sync2_i`−k) is odd;
  - `post2_i`/2 horizontal-pair lines;
  - `back2_i` dark lines;
  - `act2_i` picture lines;
  - `front2_i` dark lines;
  - `pre2_i`/2 horizontal-pair lines.
- R7: For a picture line at position j (0-based) within its picture segment, the base row is j, or j/2 (rounded down) when `dbl_i`=1. In progressive mode `img_row_o` equals the base row. On non-picture lines `img_row_o` is 0.
- R8: Interlaced picture lines give row 2·base for even fields and 2·base+1 for odd fields. With `odd_first_i`=1, field 1 is odd (type 9) and field 2 is even (type 8). With `odd_first_i`=0, field 1 is even (type 7) and field 2 is odd (type 10).
- R9: `blank_o` is 0 on picture lines (types 6 to 10) and 1 on every other type.
- R10: Changes on the configuration ports take effect only at the first line of the next frame. The frame in progress continues with its sampled values.
- R11: Segments of length zero produce no lines. A configuration that yields no lines at all gives a frame of one dark line.
- R12: Line type codes: 0 long vsync, 1 vertical pair, 2 vertical+horizontal, 3 horizontal pair, 4 horizontal+vertical, 5 dark, 6 progressive picture, 7 field-1 even, 8 field-2 even, 9 field-1 odd, 10 field-2 odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_done | input | 1 | End-of-scanline strobe, one cycle wide |
| ilace_i | input | 1 | 1 = interlaced two-field frame |
| odd_first_i | input | 1 | 1 = field 1 carries odd image rows |
| dbl_i | input | 1 | 1 = each image row shown on two lines |
| sync1_i | input | 10 | Field 1 vsync length (half-lines in interlaced mode) |
| post1_i | input | 10 | Field 1 half-lines of equalizing after vsync |
| back1_i | input | 10 | Field 1 dark lines above the picture |
| act1_i | input | 10 | Field 1 picture lines |
| front1_i | input | 10 | Field 1 dark lines below the picture |
| pre1_i | input | 10 | Half-lines of equalizing before field 2 vsync |
| sync2_i | input | 10 | Field 2 vsync half-lines |
| post2_i | input | 10 | Field 2 half-lines of equalizing after vsync |
| back2_i | input | 10 | Field 2 dark lines above the picture |
| act2_i | input | 10 | Field 2 picture lines |
| front2_i | input | 10 | Field 2 dark lines below the picture |
| pre2_i | input | 10 | Half-lines of equalizing closing the frame |
| line_type_o | output | 4 | Type code of the current line |
| img_row_o | output | 11 | Source image row of the current line |
| blank_o | output | 1 | 1 on every non-picture line |
| line_num_o | output | 14 | Current line number, from 1 |
| frame_o | output | 16 | Frame counter |

## Verification
Every output is registered. Each one is valid one clock edge after the edge that samples `line_done`: the edge that takes the strobe also loads the new line's description. The bench raises the strobe on a falling edge. A monitor notes the strobe at the following rising edge and compares the outputs at the next falling edge, once they have settled. The reset description is already present at the first falling edge after `rst` drops. A hold check waits several idle cycles with no strobe and then compares again. Configuration changes are applied part-way through a frame, so the remaining lines are checked against the old values and the next frame against the new ones.

// File: rtl/vline_pkg.sv
package vline_pkg;

  localparam int VL_CW   = 10;
  localparam int VL_NSEG = 20;
  localparam int VL_SW   = $clog2(VL_NSEG);

  typedef enum logic [3:0] {
    LT_VLONG  = 4'd0,
    LT_VV     = 4'd1,
    LT_VH     = 4'd2,
    LT_HH     = 4'd3,
    LT_HV     = 4'd4,
    LT_DARK   = 4'd5,
    LT_IMG    = 4'd6,
    LT_EVEN_A = 4'd7,
    LT_EVEN_B = 4'd8,
    LT_ODD_A  = 4'd9,
    LT_ODD_B  = 4'd10
  } ltype_e;

  // segment order is the order lines are emitted within a frame
  typedef enum logic [VL_SW-1:0] {
    SG_P_SYNC, SG_P_BACK, SG_P_ACT, SG_P_FRONT,
    SG_I_VV1, SG_I_VH1, SG_I_HH1, SG_I_BACK1, SG_I_ACT1, SG_I_FRONT1,
    SG_I_HHPRE, SG_I_HV, SG_I_VV2, SG_I_VH2, SG_I_HH2,
    SG_I_BACK2, SG_I_ACT2, SG_I_FRONT2, SG_I_HHEND,
    SG_NONE
  } seg_e;

  typedef struct packed {
    logic             ilace;
    logic             odd_first;
    logic             dbl;
    logic [VL_CW-1:0] sync1;
    logic [VL_CW-1:0] post1;
    logic [VL_CW-1:0] back1;
    logic [VL_CW-1:0] act1;
    logic [VL_CW-1:0] front1;
    logic [VL_CW-1:0] pre1;
    logic [VL_CW-1:0] sync2;
    logic [VL_CW-1:0] post2;
    logic [VL_CW-1:0] back2;
    logic [VL_CW-1:0] act2;
    logic [VL_CW-1:0] front2;
    logic [VL_CW-1:0] pre2;
  } vcfg_t;

  // number of lines a segment contributes under a configuration
  function automatic logic [VL_CW-1:0] seg_len(vcfg_t c, seg_e s);
    logic [VL_CW-1:0] k;
    logic [VL_CW-1:0] rem;
    logic [VL_CW-1:0] v;
    logic             prog_seg;
    k   = {{(VL_CW-1){1'b0}}, c.pre1[0]};
    rem = (c.sync2 >= k) ? (c.sync2 - k) : '0;
    prog_seg = 1'b0;
    case (s)
      SG_P_SYNC:   begin v = c.sync1;  prog_seg = 1'b1; end
      SG_P_BACK:   begin v = c.back1;  prog_seg = 1'b1; end
      SG_P_ACT:    begin v = c.act1;   prog_seg = 1'b1; end
      SG_P_FRONT:  begin v = c.front1; prog_seg = 1'b1; end
      SG_I_VV1:    v = c.sync1 >> 1;
      SG_I_VH1:    v = {{(VL_CW-1){1'b0}}, c.sync1[0]};
      SG_I_HH1:    v = c.post1 >> 1;
      SG_I_BACK1:  v = c.back1;
      SG_I_ACT1:   v = c.act1;
      SG_I_FRONT1: v = c.front1;
      SG_I_HHPRE:  v = c.pre1 >> 1;
      SG_I_HV:     v = k;
      SG_I_VV2:    v = rem >> 1;
      SG_I_VH2:    v = {{(VL_CW-1){1'b0}}, rem[0]};
      SG_I_HH2:    v = c.post2 >> 1;
      SG_I_BACK2:  v = c.back2;
      SG_I_ACT2:   v = c.act2;
      SG_I_FRONT2: v = c.front2;
      SG_I_HHEND:  v = c.pre2 >> 1;
      default:     v = '0;
    endcase
    if (s == SG_NONE)            return {{(VL_CW-1){1'b0}}, 1'b1};
    else if (prog_seg == c.ilace) return '0;
    else                          return v;
  endfunction

  // first non-empty segment at index >= from, SG_NONE when there is none
  function automatic seg_e seg_after(vcfg_t c, logic [VL_SW-1:0] from);
    seg_e r;
    r = SG_NONE;
    for (int i = VL_NSEG - 2; i >= 0; i--) begin
      if (i >= int'(from) && seg_len(c, seg_e'(i)) != '0) r = seg_e'(i);
    end
    return r;
  endfunction

  function automatic ltype_e seg_type(logic odd_first, seg_e s);
    case (s)
      SG_P_SYNC:                 return LT_VLONG;
      SG_I_VV1, SG_I_VV2:        return LT_VV;
      SG_I_VH1, SG_I_VH2:        return LT_VH;
      SG_I_HH1, SG_I_HHPRE,
      SG_I_HH2, SG_I_HHEND:      return LT_HH;
      SG_I_HV:                   return LT_HV;
      SG_P_ACT:                  return LT_IMG;
      SG_I_ACT1:                 return odd_first ? LT_ODD_A : LT_EVEN_A;
      SG_I_ACT2:                 return odd_first ? LT_EVEN_B : LT_ODD_B;
      default:                   return LT_DARK;
    endcase
  endfunction

endpackage

// File: rtl/vline_cfg_hold.sv
module vline_cfg_hold
  import vline_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  take,
  input  vcfg_t cfg_live,
  output vcfg_t cfg_cur,
  output vcfg_t cfg_next
);

  vcfg_t shadow_q;

  // the configuration that the next line will be described with
  always_comb begin
    if (rst || (adv && take)) cfg_next = cfg_live;
    else                      cfg_next = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst || (adv && take)) shadow_q <= cfg_live;
  end

  assign cfg_cur = shadow_q;

endmodule

// File: rtl/vline_walker.sv
module vline_walker
  import vline_pkg::*;
#(
  parameter  int FRAME_W = 16,
  localparam int LINE_W  = VL_CW + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  vcfg_t              cfg_cur,
  input  vcfg_t              cfg_next,
  output logic               take,
  output seg_e               seg_n,
  output logic [VL_CW-1:0]   idx_n,
  output logic [LINE_W-1:0]  line_n,
  output logic [FRAME_W-1:0] frame_n
);

  seg_e               seg_q;
  logic [VL_CW-1:0]   idx_q;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;

  logic [VL_CW-1:0]   cur_len;
  logic               last_in_seg;
  seg_e               follow;

  always_comb begin
    cur_len     = seg_len(cfg_cur, seg_q);
    last_in_seg = ({1'b0, idx_q} + 1'b1) >= {1'b0, cur_len};
    follow      = (seg_q == SG_NONE) ? SG_NONE
                : seg_after(cfg_cur, VL_SW'(seg_q) + 1'b1);
    take        = last_in_seg && (follow == SG_NONE);
  end

  always_comb begin
    seg_n   = seg_q;
    idx_n   = idx_q;
    line_n  = line_q;
    frame_n = frame_q;
    if (rst) begin
      seg_n   = seg_after(cfg_next, '0);
      idx_n   = '0;
      line_n  = LINE_W'(1);
      frame_n = '0;
    end else if (!last_in_seg) begin
      idx_n  = idx_q + 1'b1;
      line_n = line_q + 1'b1;
    end else if (!take) begin
      seg_n  = follow;
      idx_n  = '0;
      line_n = line_q + 1'b1;
    end else begin
      seg_n   = seg_after(cfg_next, '0);
      idx_n   = '0;
      line_n  = LINE_W'(1);
      frame_n = frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || adv) begin
      seg_q   <= seg_n;
      idx_q   <= idx_n;
      line_q  <= line_n;
      frame_q <= frame_n;
    end
  end

  // R11: the position never runs past the end of its segment
  a_r11_idx_in_seg: assert property (@(posedge clk) disable iff (rst)
    {1'b0, idx_q} < ({1'b0, seg_len(cfg_cur, seg_q)}));

endmodule

// File: rtl/vline_row_map.sv
module vline_row_map
  import vline_pkg::*;
#(
  localparam int ROW_W = VL_CW + 1
) (
  input  logic             odd_first,
  input  logic             dbl,
  input  seg_e             seg,
  input  logic [VL_CW-1:0] idx,
  output ltype_e           ltype,
  output logic [ROW_W-1:0] row,
  output logic             blank
);

  logic [VL_CW-1:0] base;
  logic             odd_bit;

  always_comb begin
    ltype   = seg_type(odd_first, seg);
    base    = dbl ? (idx >> 1) : idx;
    odd_bit = (seg == SG_I_ACT1) ? odd_first : !odd_first;
    blank   = 1'b1;
    row     = '0;
    case (seg)
      SG_P_ACT: begin
        row   = {1'b0, base};
        blank = 1'b0;
      end
      SG_I_ACT1, SG_I_ACT2: begin
        row   = {base, odd_bit};
        blank = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vline_seq.sv
module vline_seq
  import vline_pkg::*;
#(
  parameter  int FRAME_W = 16,
  localparam int ROW_W   = VL_CW + 1,
  localparam int LINE_W  = VL_CW + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_done,
  input  logic               ilace_i,
  input  logic               odd_first_i,
  input  logic               dbl_i,
  input  logic [VL_CW-1:0]   sync1_i,
  input  logic [VL_CW-1:0]   post1_i,
  input  logic [VL_CW-1:0]   back1_i,
  input  logic [VL_CW-1:0]   act1_i,
  input  logic [VL_CW-1:0]   front1_i,
  input  logic [VL_CW-1:0]   pre1_i,
  input  logic [VL_CW-1:0]   sync2_i,
  input  logic [VL_CW-1:0]   post2_i,
  input  logic [VL_CW-1:0]   back2_i,
  input  logic [VL_CW-1:0]   act2_i,
  input  logic [VL_CW-1:0]   front2_i,
  input  logic [VL_CW-1:0]   pre2_i,
  output logic [3:0]         line_type_o,
  output logic [ROW_W-1:0]   img_row_o,
  output logic               blank_o,
  output logic [LINE_W-1:0]  line_num_o,
  output logic [FRAME_W-1:0] frame_o
);

  vcfg_t              cfg_live, cfg_cur, cfg_next;
  logic               take;
  seg_e               seg_n;
  logic [VL_CW-1:0]   idx_n;
  logic [LINE_W-1:0]  line_n;
  logic [FRAME_W-1:0] frame_n;
  ltype_e             ltype_n;
  logic [ROW_W-1:0]   row_n;
  logic               blank_n;

  always_comb begin
    cfg_live.ilace     = ilace_i;
    cfg_live.odd_first = odd_first_i;
    cfg_live.dbl       = dbl_i;
    cfg_live.sync1     = sync1_i;
    cfg_live.post1     = post1_i;
    cfg_live.back1     = back1_i;
    cfg_live.act1      = act1_i;
    cfg_live.front1    = front1_i;
    cfg_live.pre1      = pre1_i;
    cfg_live.sync2     = sync2_i;
    cfg_live.post2     = post2_i;
    cfg_live.back2     = back2_i;
    cfg_live.act2      = act2_i;
    cfg_live.front2    = front2_i;
    cfg_live.pre2      = pre2_i;
  end

  vline_cfg_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .adv      (line_done),
    .take     (take),
    .cfg_live (cfg_live),
    .cfg_cur  (cfg_cur),
    .cfg_next (cfg_next)
  );

  vline_walker #(.FRAME_W(FRAME_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .adv      (line_done),
    .cfg_cur  (cfg_cur),
    .cfg_next (cfg_next),
    .take     (take),
    .seg_n    (seg_n),
    .idx_n    (idx_n),
    .line_n   (line_n),
    .frame_n  (frame_n)
  );

  vline_row_map u_map (
    .odd_first (cfg_next.odd_first),
    .dbl       (cfg_next.dbl),
    .seg       (seg_n),
    .idx       (idx_n),
    .ltype     (ltype_n),
    .row       (row_n),
    .blank     (blank_n)
  );

  always_ff @(posedge clk) begin
    if (rst || line_done) begin
      line_type_o <= ltype_n;
      img_row_o   <= row_n;
      blank_o     <= blank_n;
      line_num_o  <= line_n;
      frame_o     <= frame_n;
    end
  end

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !line_done |=> ($stable(line_num_o) && $stable(line_type_o) &&
                    $stable(img_row_o) && $stable(frame_o)));

  // R3: a strobe either steps the line or restarts at 1
  a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
    line_done |=> (line_num_o == LINE_W'(1)) ||
                  (line_num_o == $past(line_num_o) + 1'b1));

  // R3: the frame counter moves exactly when line 1 comes back
  a_r3_frame_on_wrap: assert property (@(posedge clk) disable iff (rst)
    line_done |=> ((line_num_o == LINE_W'(1)) == (frame_o != $past(frame_o))));

  // R8: field parity shows up in the row's low bit
  a_r8_parity: assert property (@(posedge clk) disable iff (rst)
    (line_type_o == LT_ODD_A || line_type_o == LT_ODD_B) |-> img_row_o[0]);
  a_r8_parity_even: assert property (@(posedge clk) disable iff (rst)
    (line_type_o == LT_EVEN_A || line_type_o == LT_EVEN_B) |-> !img_row_o[0]);

  // R9: blank agrees with the type class
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    blank_o == (line_type_o < 4'd6));

  // R12: only defined type codes appear
  a_r12_legal: assert property (@(posedge clk) disable iff (rst)
    line_type_o <= 4'd10);

endmodule

// File: tb/vline_seq_tb.sv
module vline_seq_tb_top;
  import vline_pkg::*;

  localparam int FRAME_W = 16;
  localparam int ROW_W   = VL_CW + 1;
  localparam int LINE_W  = VL_CW + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_done = 1'b0;
  logic ilace, odd_first, dbl;
  logic [VL_CW-1:0] s1, p1, b1, a1, f1, r1, s2, p2, b2, a2, f2, r2;
  logic [3:0]         line_type_o;
  logic [ROW_W-1:0]   img_row_o;
  logic               blank_o;
  logic [LINE_W-1:0]  line_num_o;
  logic [FRAME_W-1:0] frame_o;

  always #10 clk = ~clk;  // 50 MHz

  vline_seq #(.FRAME_W(FRAME_W)) dut_i (
    .clk(clk), .rst(rst), .line_done(line_done),
    .ilace_i(ilace), .odd_first_i(odd_first), .dbl_i(dbl),
    .sync1_i(s1), .post1_i(p1), .back1_i(b1), .act1_i(a1), .front1_i(f1),
    .pre1_i(r1), .sync2_i(s2), .post2_i(p2), .back2_i(b2), .act2_i(a2),
    .front2_i(f2), .pre2_i(r2),
    .line_type_o(line_type_o), .img_row_o(img_row_o), .blank_o(blank_o),
    .line_num_o(line_num_o), .frame_o(frame_o)
  );

  typedef struct {
    int    ltype;
    int    row;
    int    blank;
    int    line;
    int    frame;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t last_it;
  int checks = 0;
  int fails = 0;
  int model_frame = 0;
  int model_line;
  int pending_len;
  string first_tag;
  logic strobed = 1'b0;

  task automatic compare(exp_t it);
    checks++;
    if (int'(line_type_o) != it.ltype || int'(img_row_o) != it.row ||
        int'(line_num_o) != it.line || int'(frame_o) != it.frame) begin
      fails++;
      $display("FAIL %s: type/row/line/frame actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               it.tag, line_type_o, img_row_o, line_num_o, frame_o,
               it.ltype, it.row, it.line, it.frame);
    end
    checks++;
    if (int'(blank_o) != it.blank) begin
      fails++;
      $display("FAIL R9: blank actual %0d expected %0d (line %0d)", blank_o, it.blank, it.line);
    end
    last_it = it;
  endtask

  // model: append n lines of one type
  task automatic add(int lt, int n, string tag);
    for (int j = 0; j < n; j++) begin
      exp_t it;
      int base;
      base = dbl ? j / 2 : j;
      it.ltype = lt;
      it.blank = (lt >= 6) ? 0 : 1;
      case (lt)
        6:       it.row = base;
        7, 8:    it.row = 2 * base;
        9, 10:   it.row = 2 * base + 1;
        default: it.row = 0;
      endcase
      it.line  = model_line;
      it.frame = model_frame;
      it.tag   = (model_line == 1 && first_tag != "") ? first_tag : tag;
      model_line++;
      q.push_back(it);
    end
  endtask

  // model: one whole frame from the configuration now on the ports
  task automatic push_frame(string ftag);
    int k, rm;
    first_tag  = ftag;
    model_line = 1;
    if (!ilace) begin
      add(0, int'(s1), "R12");
      add(5, int'(b1), "R4");
      add(6, int'(a1), "R7");
      add(5, int'(f1), "R4");
    end else begin
      add(1, int'(s1) / 2, "R5");
      add(2, int'(s1) % 2, "R5");
      add(3, int'(p1) / 2, "R5");
      add(5, int'(b1), "R5");
      add(odd_first ? 9 : 7, int'(a1), "R8");
      add(5, int'(f1), "R5");
      k = int'(r1) % 2;
      add(3, int'(r1) / 2, "R6");
      add(4, k, "R6");
      rm = (int'(s2) >= k) ? int'(s2) - k : 0;
      add(1, rm / 2, "R6");
      add(2, rm % 2, "R6");
      add(3, int'(p2) / 2, "R6");
      add(5, int'(b2), "R6");
      add(odd_first ? 8 : 10, int'(a2), "R8");
      add(5, int'(f2), "R6");
      add(3, int'(r2) / 2, "R6");
    end
    if (model_line == 1) add(5, 1, "R11");
    pending_len = model_line - 1;
    model_frame++;
  endtask

  // monitor: one compare per strobe, when the registered outputs have settled
  always @(posedge clk) strobed <= line_done && !rst;
  always @(negedge clk) begin
    if (strobed) begin
      if (q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R3: unexpected line, actual line %0d expected none", line_num_o);
      end else begin
        compare(q.pop_front());
      end
    end
  end

  task automatic step();
    @(negedge clk);
    line_done = 1'b1;
    @(negedge clk);
    #1;
    line_done = 1'b0;
  endtask

  task automatic step_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // run until the first line of the last pushed frame has been observed
  task automatic advance();
    while (q.size() >= pending_len) step();
  endtask

  // R2: idle cycles leave the outputs unchanged
  task automatic hold_check();
    repeat (6) @(negedge clk);
    compare('{last_it.ltype, last_it.row, last_it.blank, last_it.line,
              last_it.frame, "R2"});
  endtask

  task automatic set_zero();
    {s1, p1, b1, a1, f1, r1, s2, p2, b2, a2, f2, r2} = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // progressive, no doubling
    ilace = 1'b0; odd_first = 1'b0; dbl = 1'b0;
    set_zero();
    s1 = 2; b1 = 3; a1 = 5; f1 = 2;
    push_frame("R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare(q.pop_front());  // R1 reset state
    step_n(3);
    // R10: enable doubling mid-frame; rest of frame 0 must not see it
    dbl = 1'b1;
    push_frame("R3");
    advance();
    step_n(2);
    hold_check();
    // switch to interlaced, odd rows first
    ilace = 1'b1; odd_first = 1'b1; dbl = 1'b0;
    s1 = 5; p1 = 5; b1 = 2; a1 = 4; f1 = 1; r1 = 5;
    s2 = 5; p2 = 4; b2 = 2; a2 = 4; f2 = 1; r2 = 6;
    push_frame("R10");
    advance();
    step_n(10);
    // interlaced, even rows first, doubled
    odd_first = 1'b0; dbl = 1'b1;
    s1 = 6; p1 = 6; b1 = 1; a1 = 3; f1 = 2; r1 = 4;
    s2 = 5; p2 = 3; b2 = 1; a2 = 3; f2 = 2; r2 = 2;
    push_frame("R3");
    advance();
    hold_check();
    // R11: empty configuration gives single dark-line frames
    ilace = 1'b0;
    set_zero();
    push_frame("R11");
    advance();
    push_frame("R11");
    advance();
    push_frame("R11");
    advance();
    hold_check();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule